// File: doc/BRIEF.md
# Infrared Remote Carrier Modulator

This block produces the waveform for an infrared remote-control transmitter. Two counters share one clock. An 8-bit carrier counter makes a square carrier, and a 16-bit data counter makes the symbol envelope. The pin output is the carrier ANDed with the envelope, and it can be inverted. The envelope is high while the data counter is below an active length. The symbol ends when the counter reaches a total length. Firmware drives a simple write port to load the carrier period, the carrier high time and the two lengths. Level and pulse controls start, stop and reset the counters and select the modes.

The two length values can be double-buffered. In that mode a write lands in a staging copy and moves into the active pair only at the next total-length match. Software can therefore queue the next symbol while the current one runs, and symbols follow each other with no idle clock between them. Two sticky event flags mark the active-length match and the total-length match. Each flag can be masked into a single interrupt line.

Top module: `irModulator`

## Requirements
- R1: After reset the block is idle (`running`=0), with `irOut`=0, `xferPending`=0, `irqFlags`=0 and `irq`=0. Every period, high-time and length register resets to 0.
- R2: While running, the carrier counter starts at 0 and counts to the carrier period value P, then wraps, so one carrier cycle lasts P+1 clocks. The carrier is high while the counter is at or below the high-time value H. H>=P gives a carrier that never goes low.
- R3: While running in repeat mode (`oneShot`=0), the data counter runs 0..T and wraps to 0, where T is the total length. The envelope is high while the counter is below the active length A. `irOut` = envelope AND carrier. Both counters start from 0 on the first running clock.
- R4: In one-shot mode (`oneShot`=1), the clock in which the data counter equals T clears `running` and returns the data counter to 0. The output then stays idle.
- R5: A `runSet` pulse starts both counters and a `runClr` pulse stops them; `runClr` wins if both are given. `running` reads 1 while counting. Stopping returns the carrier counter to 0 and holds the data counter.
- R6: A `cntReset` pulse clears the data counter to 0.
- R7: With `bufEn`=1, writes to A (`wrSel`=2) or T (`wrSel`=3) go to staging copies and set `xferPending`. At the next total-length match while running, both staged values move into the active pair and `xferPending` clears.
- R8: With `bufEn`=0, length writes take effect at once and leave `xferPending` at 0. Writes with `wrSel`=0 set P and writes with `wrSel`=1 set H, always directly.
- R9: With `carEn`=0, `irOut` is the envelope alone.
- R10: With `invEn`=1, `irOut` is inverted, including while idle (idle output is 1).
- R11: `irqFlags[0]` sets when the data counter equals A while running, and `irqFlags[1]` sets when it equals T while running. Writing 1 to the matching `flagClr` bit clears a flag. `irq` is high when any flag is set and its `irqEn` bit is 1 (bit 0 = active match, bit 1 = total match).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runSet | input | 1 | Start pulse |
| runClr | input | 1 | Stop pulse |
| cntReset | input | 1 | Pulse that clears the data counter |
| oneShot | input | 1 | 1 = stop after one symbol, 0 = repeat |
| bufEn | input | 1 | 1 = stage length writes until the next total match |
| carEn | input | 1 | 1 = gate the envelope with the carrier |
| invEn | input | 1 | 1 = invert the output |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | 0 period, 1 high time, 2 active length, 3 total length |
| wrData | input | 16 | Write data (low 8 bits for carrier registers) |
| flagClr | input | 2 | Write-1-to-clear for the event flags |
| irqEn | input | 2 | Interrupt enables for the event flags |
| irOut | output | 1 | Modulated output |
| running | output | 1 | Counting status |
| xferPending | output | 1 | Staged length values not yet loaded |
| irqFlags | output | 2 | Sticky flags: bit 0 active match, bit 1 total match |
| irq | output | 1 | Interrupt request |

## Verification
The output is compared clock by clock against carrier and envelope patterns with different periods, high times and lengths. These include a short high time, a high time at or above the period, and a constant carrier, which tell the carrier wrap point apart from the envelope edge. Separate patterns run with the carrier disabled, with the output inverted, and in one-shot mode, which shows whether the gating, the polarity and the automatic stop act independently. A symbol queued through the staging copies must show the old lengths for exactly one symbol and the new ones from the next clock on. A stop, reset and restart must replay the pattern from phase zero, which shows that the counter reset really took effect.

// File: rtl/irModPkg.sv
package irModPkg;
  typedef enum logic [1:0] {
    SEL_CAR_PERIOD = 2'd0,
    SEL_CAR_HIGH   = 2'd1,
    SEL_ACT_LEN    = 2'd2,
    SEL_TOT_LEN    = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic count;      // counters advance
    logic datClr;     // data counter back to zero
    logic loadStaged; // staged lengths into active pair
  } dpStrobe_t;
endpackage

// File: rtl/irModDatapath.sv
module irModDatapath
  import irModPkg::*;
#(
  parameter int CAR_W = 8,
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [DAT_W-1:0] wrData,
  input  logic             bufEn,
  input  logic             carEn,
  input  logic             invEn,
  output logic             actHit,
  output logic             totHit,
  output logic             irOut
);
  logic [CAR_W-1:0] carCnt, carPeriod, carHigh;
  logic [DAT_W-1:0] datCnt, actLen, totLen, actStage, totStage;
  logic carOn, envOn;

  // carrier counter: 0..carPeriod, cleared while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carCnt <= '0;
    else if (!strobe.count) carCnt <= '0;
    else if (carCnt >= carPeriod) carCnt <= '0;
    else carCnt <= carCnt + 1'b1;
  end

  // data counter: holds while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) datCnt <= '0;
    else if (strobe.datClr) datCnt <= '0;
    else if (strobe.count) datCnt <= datCnt + 1'b1;
  end

  // configuration registers with staging copies for the lengths
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carPeriod <= '0;
      carHigh   <= '0;
      actLen    <= '0;
      totLen    <= '0;
      actStage  <= '0;
      totStage  <= '0;
    end else begin
      if (strobe.loadStaged) begin
        actLen <= actStage;
        totLen <= totStage;
      end
      if (wrEn) begin
        case (regSel_e'(wrSel))
          SEL_CAR_PERIOD: carPeriod <= wrData[CAR_W-1:0];
          SEL_CAR_HIGH:   carHigh   <= wrData[CAR_W-1:0];
          SEL_ACT_LEN: begin
            actStage <= wrData;
            if (!bufEn) actLen <= wrData;
          end
          SEL_TOT_LEN: begin
            totStage <= wrData;
            if (!bufEn) totLen <= wrData;
          end
          default: ;
        endcase
      end
    end
  end

  assign actHit = (datCnt == actLen);
  assign totHit = (datCnt == totLen);
  assign carOn  = carEn ? (carCnt <= carHigh) : 1'b1;
  assign envOn  = strobe.count && (datCnt < actLen);
  assign irOut  = (envOn && carOn) ^ invEn;
endmodule

// File: rtl/irModCtrl.sv
module irModCtrl
  import irModPkg::*;
#(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runSet,
  input  logic             runClr,
  input  logic             cntReset,
  input  logic             oneShot,
  input  logic             bufEn,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [NFLAG-1:0] flagClr,
  input  logic [NFLAG-1:0] irqEn,
  input  logic             actHit,
  input  logic             totHit,
  output dpStrobe_t        strobe,
  output logic             running,
  output logic             xferPending,
  output logic [NFLAG-1:0] irqFlags,
  output logic             irq
);
  logic symEnd, stageWr;
  logic [NFLAG-1:0] hitVec;

  assign symEnd  = running && totHit;
  assign stageWr = wrEn && bufEn &&
                   ((regSel_e'(wrSel) == SEL_ACT_LEN) || (regSel_e'(wrSel) == SEL_TOT_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else if (runClr) running <= 1'b0;
    else if (runSet) running <= 1'b1;
    else if (symEnd && oneShot) running <= 1'b0;
  end

  // staged write wins over a same-cycle transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xferPending <= 1'b0;
    else if (stageWr) xferPending <= 1'b1;
    else if (symEnd) xferPending <= 1'b0;
  end

  assign strobe.count      = running;
  assign strobe.datClr     = cntReset || symEnd;
  assign strobe.loadStaged = symEnd && xferPending;

  assign hitVec = {NFLAG{running}} & {{(NFLAG-1){totHit}}, actHit};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqFlags[i] <= 1'b0;
      else if (hitVec[i]) irqFlags[i] <= 1'b1;
      else if (flagClr[i]) irqFlags[i] <= 1'b0;
    end
  end

  assign irq = |(irqFlags & irqEn);
endmodule

// File: rtl/irModulator.sv
module irModulator
  import irModPkg::*;
#(
  parameter int CAR_W = 8,
  parameter int DAT_W = 16,
  localparam int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runSet,
  input  logic             runClr,
  input  logic             cntReset,
  input  logic             oneShot,
  input  logic             bufEn,
  input  logic             carEn,
  input  logic             invEn,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [DAT_W-1:0] wrData,
  input  logic [NFLAG-1:0] flagClr,
  input  logic [NFLAG-1:0] irqEn,
  output logic             irOut,
  output logic             running,
  output logic             xferPending,
  output logic [NFLAG-1:0] irqFlags,
  output logic             irq
);
  dpStrobe_t strobe;
  logic actHit, totHit;

  irModCtrl #(.NFLAG(NFLAG)) ctrl_i (
    .clk(clk), .rstN(rstN), .runSet(runSet), .runClr(runClr),
    .cntReset(cntReset), .oneShot(oneShot), .bufEn(bufEn),
    .wrEn(wrEn), .wrSel(wrSel), .flagClr(flagClr), .irqEn(irqEn),
    .actHit(actHit), .totHit(totHit), .strobe(strobe),
    .running(running), .xferPending(xferPending),
    .irqFlags(irqFlags), .irq(irq)
  );

  irModDatapath #(.CAR_W(CAR_W), .DAT_W(DAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .bufEn(bufEn), .carEn(carEn),
    .invEn(invEn), .actHit(actHit), .totHit(totHit), .irOut(irOut)
  );
endmodule

// File: rtl/irModChecker.sv
module irModChecker (
  input logic       clk,
  input logic       rstN,
  input logic       runSet,
  input logic       runClr,
  input logic       oneShot,
  input logic       bufEn,
  input logic       wrEn,
  input logic [1:0] wrSel,
  input logic [1:0] flagClr,
  input logic       invEn,
  input logic       running,
  input logic       xferPending,
  input logic [1:0] irqFlags,
  input logic       irOut
);
  // R1 / R10: idle and non-inverted means a quiet pin
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !invEn) |-> !irOut);

  a_r5_start: assert property (@(posedge clk) disable iff (!rstN)
    (runSet && !runClr) |=> running);

  a_r5_stop: assert property (@(posedge clk) disable iff (!rstN)
    runClr |=> !running);

  // R4: a stop not caused by runClr only happens in one-shot mode
  a_r4_self_stop: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(running) && !$past(runClr)) |-> $past(oneShot));

  a_r7_stage_pending: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && bufEn && wrSel[1]) |=> xferPending);

  a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr[0] && !running) |=> !irqFlags[0]);
endmodule

bind irModulator irModChecker chk_i (.*);

// File: tb/irModulator_tb.sv
module irModulator_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runSet = 0, runClr = 0, cntReset = 0, oneShot = 0, bufEn = 0;
  logic carEn = 1, invEn = 0, wrEn = 0;
  logic [1:0] wrSel = 0;
  logic [15:0] wrData = 0;
  logic [1:0] flagClr = 0, irqEn = 0;
  logic irOut, running, xferPending, irq;
  logic [1:0] irqFlags;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { logic v; string req; } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  irModulator dut_i (
    .clk(clk), .rstN(rstN), .runSet(runSet), .runClr(runClr),
    .cntReset(cntReset), .oneShot(oneShot), .bufEn(bufEn), .carEn(carEn),
    .invEn(invEn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .flagClr(flagClr), .irqEn(irqEn), .irOut(irOut), .running(running),
    .xferPending(xferPending), .irqFlags(irqFlags), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: one expected output per clock
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      chk(e.req, {31'b0, irOut}, {31'b0, e.v});
    end
  end

  function automatic logic model(int k, int a, int t, int p, int h, bit os);
    int d;
    bit env, car;
    d = os ? k : k % (t + 1);
    env = os ? (k <= t && k < a) : (d < a);
    car = carEn ? ((k % (p + 1)) <= h) : 1'b1;
    return (env & car) ^ invEn;
  endfunction

  task automatic wrReg(logic [1:0] sel, logic [15:0] val);
    @(negedge clk); wrEn = 1; wrSel = sel; wrData = val;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic startRun();
    @(negedge clk); runSet = 1;
    @(posedge clk); #1 runSet = 0;
  endtask

  task automatic stopRun();
    @(negedge clk); runClr = 1;
    @(negedge clk); runClr = 0;
  endtask

  task automatic clrCnt();
    @(negedge clk); cntReset = 1;
    @(negedge clk); cntReset = 0;
  endtask

  task automatic waitQ();
    while (expQ.size() > 0) @(posedge clk);
  endtask

  // driver: start and push the expected pattern
  task automatic runExpect(int n, int a, int t, int p, int h, bit os, string req);
    startRun();
    for (int k = 0; k < n; k++) expQ.push_back('{model(k, a, t, p, h, os), req});
    waitQ();
  endtask

  task automatic setAll(int p, int h, int a, int t);
    wrReg(2'd0, p[15:0]); wrReg(2'd1, h[15:0]);
    wrReg(2'd2, a[15:0]); wrReg(2'd3, t[15:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irOut", irOut, 0);
    chk("R1 running", running, 0);
    chk("R1 pending", xferPending, 0);
    chk("R1 flags", irqFlags, 0);
    chk("R1 irq", irq, 0);

    // R2 carrier with short high time
    setAll(3, 1, 30, 30);
    runExpect(16, 30, 30, 3, 1, 0, "R2 carrier P3 H1");
    stopRun();
    chk("R5 stopped", running, 0);
    chk("R5 idle out", irOut, 0);
    clrCnt();

    // R2 high time at the period: never low
    setAll(2, 2, 30, 30);
    runExpect(8, 30, 30, 2, 2, 0, "R2 carrier H>=P");
    stopRun(); clrCnt();

    // R3 repeat envelope with constant carrier
    setAll(0, 0, 2, 5);
    runExpect(14, 2, 5, 0, 0, 0, "R3 repeat envelope");
    @(negedge clk);
    chk("R11 both flags", irqFlags, 2'b11);
    chk("R11 masked irq", irq, 0);
    irqEn = 2'b10; #1;
    chk("R11 irq enabled", irq, 1);
    stopRun();
    @(negedge clk); flagClr = 2'b01;
    @(negedge clk); flagClr = 2'b00;
    chk("R11 clear active flag", irqFlags, 2'b10);
    chk("R11 irq still", irq, 1);
    @(negedge clk); flagClr = 2'b10;
    @(negedge clk); flagClr = 2'b00;
    chk("R11 clear total flag", irqFlags, 2'b00);
    chk("R11 irq dropped", irq, 0);
    irqEn = 2'b00;
    clrCnt();

    // R9 envelope only
    carEn = 0;
    setAll(3, 0, 3, 6);
    runExpect(10, 3, 6, 3, 0, 0, "R9 carrier off");
    stopRun(); clrCnt();
    carEn = 1;

    // R10 inversion
    @(negedge clk); invEn = 1; #1;
    chk("R10 idle inverted", irOut, 1);
    setAll(1, 0, 3, 5);
    runExpect(12, 3, 5, 1, 0, 0, "R10 inverted");
    stopRun();
    chk("R10 idle after stop", irOut, 1);
    @(negedge clk); invEn = 0;
    clrCnt();

    // R6 counter reset replays from phase zero
    setAll(0, 0, 3, 7);
    startRun();
    repeat (5) @(negedge clk);
    stopRun(); clrCnt();
    runExpect(9, 3, 7, 0, 0, 0, "R6 reset replay");
    stopRun(); clrCnt();

    // R8 direct writes / R7 staged writes
    setAll(0, 0, 2, 5);
    @(negedge clk);
    chk("R8 no pending", xferPending, 0);
    bufEn = 1;
    wrReg(2'd2, 16'd4); wrReg(2'd3, 16'd9);
    @(negedge clk);
    chk("R7 pending set", xferPending, 1);
    startRun();
    for (int k = 0; k < 6; k++) expQ.push_back('{(k < 2), "R7 old symbol"});
    for (int k = 0; k < 10; k++) expQ.push_back('{(k < 4), "R7 new symbol"});
    waitQ();
    @(negedge clk);
    chk("R7 pending cleared", xferPending, 0);
    stopRun(); clrCnt();
    bufEn = 0;

    // R4 one-shot
    oneShot = 1;
    setAll(1, 0, 3, 4);
    runExpect(10, 3, 4, 1, 0, 1, "R4 one-shot");
    @(negedge clk);
    chk("R4 self stop", running, 0);
    chk("R4 idle out", irOut, 0);
    oneShot = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule